// File: doc/BRIEF.md
# Double-Buffered Dual DAC Code Loader

This block is the digital front end of a pair of 12-bit converters. A host writes each channel's code over an 8-bit parallel bus in two transfers: one byte holding the eight low bits, and one nibble holding the four high bits. The nibble is right-justified, so it is taken from bus lines 3..0. The bytes go into a first rank of holding registers. A separate update strobe then copies both channels' holding registers into a second rank. That second rank drives the two 12-bit code outputs, so both outputs move on the same clock edge.

The block runs on a system clock. The bus strobes are asynchronous to it and pass through a two-flop synchronizer. A transfer is committed when the write strobe is released, using the select, update, address and data values that were present while write was still low. An active-low clear empties both ranks at once, without waiting for a clock edge. Clear overrides any write or update that commits while it is held. A synchronous active-high reset returns the whole block, synchronizer included, to idle.

Top module: `dual_dac_loader`

## Requirements
- R1: After reset both code outputs are 0.
- R2: A committed write with `addr`=2'b00 stores `data[7:0]` as bits 7..0 of channel A's holding code, and `addr`=2'b10 does the same for channel B.
- R3: A committed write with `addr`=2'b01 (channel A) or 2'b11 (channel B) stores `data[3:0]` as bits 11..8 of that channel's holding code. `data[7:4]` has no effect on that transfer.
- R4: Address bit 1 selects the channel (0 = A, 1 = B). Address bit 0 selects the part (0 = low byte, 1 = high nibble). A write touches only the one register it addresses.
- R5: A write pulse with `cs_n` high changes no holding register.
- R6: Writes to holding registers never change `code_a` or `code_b` unless an update commits.
- R7: A write pulse with `upd_n` low copies both holding codes to `code_a` and `code_b` on the same clock edge.
- R8: When `cs_n` and `upd_n` are both low in one write pulse, the addressed register is written first, and the update carries the newly written value.
- R9: Driving `clr_n` low zeroes both holding codes and both outputs at once, with no clock edge needed.
- R10: While `clr_n` is low, a write or update that commits has no effect.
- R11: A transfer commits on the third rising clock edge after `wr_n` rises. Holding `wr_n` low for any length of time commits nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Asynchronous clear of both ranks, active low |
| cs_n | input | 1 | Chip select for holding-register writes, active low |
| wr_n | input | 1 | Write strobe, active low; its release commits |
| upd_n | input | 1 | Update request for the output rank, active low |
| addr | input | 2 | Holding-register select: bit 1 channel, bit 0 part |
| data | input | 8 | Parallel data bus |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |

## Verification
The bench builds the block with its default values: 12-bit codes, an 8-bit bus and a two-stage synchronizer. With these values the commit lands exactly three edges after the write strobe is released, so the bench can check the latency edge by edge. The 8/4 split also makes the ignored upper nibble lines and the partial-register writes visible. A behavioural model that keeps a sample history of the bus is compared against both outputs on every cycle. Targeted cases cover a strobe with select high, a combined write-and-update, a long-held strobe, and a clear that is still asserted while transfers commit.

// File: rtl/dac_ld_pkg.sv
package dac_ld_pkg;

    localparam int DL_CODE_W = 12;
    localparam int DL_LO_W   = 8;
    localparam int DL_SYNC   = 2;
    localparam int DL_NCH    = 2;

    typedef enum logic {
        PART_LO = 1'b0,
        PART_HI = 1'b1
    } part_e;

    typedef struct packed {
        logic fire;     // write strobe was released this cycle
        logic cs_act;   // select was low while strobe was low
        logic upd_act;  // update was low while strobe was low
    } strobe_evt_t;

    // Register select code: channel index above, part below.
    function automatic logic [1:0] reg_sel(input int ch, input part_e part);
        logic [1:0] sel;
        sel[1] = ch[0];
        sel[0] = part;
        return sel;
    endfunction

endpackage

// File: rtl/dac_ld_sync.sv
module dac_ld_sync #(
    parameter int             W      = 1,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= IDLE;
                else     chain[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= IDLE;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/dac_ld_strobe.sv
module dac_ld_strobe
    import dac_ld_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_s,
    input  logic          cs_s,
    input  logic          upd_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output strobe_evt_t   evt,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    logic wr_d, cs_d, upd_d;

    // Hold the previous synchronized sample: its fields are the ones
    // seen while the strobe was still low when the strobe rises.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_d   <= 1'b1;
            cs_d   <= 1'b1;
            upd_d  <= 1'b1;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            wr_d   <= wr_s;
            cs_d   <= cs_s;
            upd_d  <= upd_s;
            addr_q <= addr_s;
            data_q <= data_s;
        end
    end

    always_comb begin
        evt.fire    = wr_s & ~wr_d;
        evt.cs_act  = ~cs_d;
        evt.upd_act = ~upd_d;
    end
endmodule

// File: rtl/dac_ld_channel.sv
module dac_ld_channel #(
    parameter int CODE_W = 12,
    parameter int LO_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              xfer,
    input  logic [LO_W-1:0]   din,
    output logic [CODE_W-1:0] staged,
    output logic [CODE_W-1:0] dac
);
    localparam int HI_W = CODE_W - LO_W;

    logic [LO_W-1:0] lo_q, lo_n;
    logic [HI_W-1:0] hi_q, hi_n;

    always_comb begin
        lo_n   = wr_lo ? din : lo_q;
        hi_n   = wr_hi ? din[HI_W-1:0] : hi_q;
        staged = {hi_n, lo_n};
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            lo_q <= '0;
            hi_q <= '0;
            dac  <= '0;
        end else if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
            dac  <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
            if (xfer) dac <= staged;
        end
    end
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dac_ld_pkg::*;
#(
    parameter int CODE_W      = DL_CODE_W,
    parameter int LO_W        = DL_LO_W,
    parameter int SYNC_STAGES = DL_SYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              upd_n,
    input  logic [1:0]        addr,
    input  logic [LO_W-1:0]   data,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);
    localparam int NCH   = DL_NCH;
    localparam int AW    = 2;
    localparam int SYN_W = 3 + AW + LO_W;
    localparam logic [SYN_W-1:0] SYN_IDLE = {3'b111, {(AW + LO_W){1'b0}}};

    logic [SYN_W-1:0] raw_bus, syn_bus;
    strobe_evt_t      evt;
    logic [AW-1:0]    addr_q;
    logic [LO_W-1:0]  data_q;

    logic                       load_fire;
    logic                       xfer_fire;
    logic [NCH-1:0]             wr_lo, wr_hi;
    logic [NCH-1:0][CODE_W-1:0] staged_code;
    logic [NCH-1:0][CODE_W-1:0] dac_code;

    assign raw_bus = {wr_n, cs_n, upd_n, addr, data};

    dac_ld_sync #(
        .W      (SYN_W),
        .STAGES (SYNC_STAGES),
        .IDLE   (SYN_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_bus),
        .dout (syn_bus)
    );

    dac_ld_strobe #(
        .AW (AW),
        .DW (LO_W)
    ) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .wr_s   (syn_bus[SYN_W-1]),
        .cs_s   (syn_bus[SYN_W-2]),
        .upd_s  (syn_bus[SYN_W-3]),
        .addr_s (syn_bus[LO_W +: AW]),
        .data_s (syn_bus[LO_W-1:0]),
        .evt    (evt),
        .addr_q (addr_q),
        .data_q (data_q)
    );

    assign load_fire = evt.fire & evt.cs_act;
    assign xfer_fire = evt.fire & evt.upd_act;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign wr_lo[ch] = load_fire & (addr_q == reg_sel(ch, PART_LO));
        assign wr_hi[ch] = load_fire & (addr_q == reg_sel(ch, PART_HI));

        dac_ld_channel #(
            .CODE_W (CODE_W),
            .LO_W   (LO_W)
        ) u_chan (
            .clk    (clk),
            .rst    (rst),
            .clr_n  (clr_n),
            .wr_lo  (wr_lo[ch]),
            .wr_hi  (wr_hi[ch]),
            .xfer   (xfer_fire),
            .din    (data_q),
            .staged (staged_code[ch]),
            .dac    (dac_code[ch])
        );
    end

    assign code_a = dac_code[0];
    assign code_b = dac_code[1];
endmodule

// File: rtl/dual_dac_loader_chk.sv
module dual_dac_loader_chk #(
    parameter int CODE_W = 12
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   clr_n,
    input logic                   load_fire,
    input logic                   xfer_fire,
    input logic [1:0][CODE_W-1:0] staged_code,
    input logic [CODE_W-1:0]      code_a,
    input logic [CODE_W-1:0]      code_b
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code_a == '0 && code_b == '0));

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (code_a == '0 && code_b == '0));

    // R6
    hold_no_upd_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !xfer_fire |=> ($stable(code_a) && $stable(code_b)));

    // R6
    load_only_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (load_fire && !xfer_fire) |=> ($stable(code_a) && $stable(code_b)));

    // R7
    xfer_both_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        xfer_fire |=> (code_a == $past(staged_code[0]) && code_b == $past(staged_code[1])));
endmodule

bind dual_dac_loader dual_dac_loader_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_n       (clr_n),
    .load_fire   (load_fire),
    .xfer_fire   (xfer_fire),
    .staged_code (staged_code),
    .code_a      (code_a),
    .code_b      (code_b)
);

// File: tb/dual_dac_loader_tb.sv
`timescale 1ns/1ps
module dual_dac_loader_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        upd_n = 1'b1;
    logic [1:0]  addr = 2'b00;
    logic [7:0]  data = 8'h00;
    logic [11:0] code_a, code_b;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dual_dac_loader u_dut (
        .clk    (clk),
        .rst    (rst),
        .clr_n  (clr_n),
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .upd_n  (upd_n),
        .addr   (addr),
        .data   (data),
        .code_a (code_a),
        .code_b (code_b)
    );

    // Behavioural model: sample history of the raw bus.
    typedef struct packed {
        logic       wr;
        logic       cs;
        logic       upd;
        logic [1:0] ad;
        logic [7:0] dt;
    } smp_t;

    localparam smp_t IDLE_SMP = '{wr: 1'b1, cs: 1'b1, upd: 1'b1, ad: 2'b00, dt: 8'h00};

    smp_t        hist[$];
    logic [11:0] m_in  [2];
    logic [11:0] m_dac [2];

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            for (int i = 0; i < 3; i++) hist.push_back(IDLE_SMP);
            for (int c = 0; c < 2; c++) begin m_in[c] = '0; m_dac[c] = '0; end
        end else begin
            hist.push_back('{wr: wr_n, cs: cs_n, upd: upd_n, ad: addr, dt: data});
            if (hist.size() > 4) void'(hist.pop_front());
            if (!clr_n) begin
                for (int c = 0; c < 2; c++) begin m_in[c] = '0; m_dac[c] = '0; end
            end else if (hist[1].wr && !hist[0].wr) begin
                smp_t p;
                int   ch;
                p  = hist[0];
                ch = p.ad[1];
                if (!p.cs) begin
                    if (p.ad[0]) m_in[ch][11:8] = p.dt[3:0];
                    else         m_in[ch][7:0]  = p.dt;
                end
                if (!p.upd) begin
                    m_dac[0] = m_in[0];
                    m_dac[1] = m_in[1];
                end
            end
        end
    end

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%03h expected=%03h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R11 timing, R7 together).
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R11 model A", code_a, clr_n ? m_dac[0] : 12'h000);
            check("R11 model B", code_b, clr_n ? m_dac[1] : 12'h000);
        end
    end

    task automatic bus_op(input logic cs, input logic upd, input logic [1:0] a,
                          input logic [7:0] d, input int hold);
        @(negedge clk);
        cs_n = cs; upd_n = upd; addr = a; data = d; wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; upd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 reset A", code_a, 12'h000);
        check("R1 reset B", code_b, 12'h000);

        // R2 R3 R4: fill both holding codes, upper nibble lines set
        bus_op(1'b0, 1'b1, 2'b00, 8'h5A, 2);
        bus_op(1'b0, 1'b1, 2'b01, 8'hF3, 2);
        bus_op(1'b0, 1'b1, 2'b10, 8'h0F, 2);
        bus_op(1'b0, 1'b1, 2'b11, 8'h9C, 2);
        // R6
        check("R6 no update A", code_a, 12'h000);
        check("R6 no update B", code_b, 12'h000);

        // R7 R11: update-only pulse, checked edge by edge
        @(negedge clk);
        upd_n = 1'b0; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        // R11: long low strobe commits nothing
        check("R11 held low A", code_a, 12'h000);
        wr_n = 1'b1;
        @(negedge clk);
        upd_n = 1'b1;
        check("R11 edge1 A", code_a, 12'h000);
        @(negedge clk);
        check("R11 edge2 B", code_b, 12'h000);
        @(negedge clk);
        check("R7 R3 R2 A", code_a, 12'h35A);
        check("R7 R4 B", code_b, 12'hC0F);
        repeat (3) @(negedge clk);

        // R5: select high, then update
        bus_op(1'b1, 1'b1, 2'b00, 8'hFF, 2);
        bus_op(1'b1, 1'b0, 2'b00, 8'h00, 2);
        check("R5 A unchanged", code_a, 12'h35A);

        // R8: combined write and update
        bus_op(1'b0, 1'b0, 2'b00, 8'h11, 3);
        check("R8 A new", code_a, 12'h311);
        check("R8 B kept", code_b, 12'hC0F);

        // R3: nibble write ignores bits 7..4
        bus_op(1'b0, 1'b0, 2'b11, 8'hA7, 2);
        check("R3 B nibble", code_b, 12'h70F);
        check("R4 A untouched", code_a, 12'h311);

        // R9: asynchronous clear, checked between edges
        @(negedge clk);
        #1 clr_n = 1'b0;
        #0.5;
        check("R9 async A", code_a, 12'h000);
        check("R9 async B", code_b, 12'h000);

        // R10: transfer committing while clear held
        bus_op(1'b0, 1'b0, 2'b01, 8'h0E, 2);
        check("R10 clr held A", code_a, 12'h000);
        @(negedge clk);
        clr_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_op(1'b1, 1'b0, 2'b00, 8'h00, 2);
        // R9: holding rank was emptied too
        check("R9 holding A", code_a, 12'h000);
        check("R9 holding B", code_b, 12'h000);

        // R2: fresh low byte on B after clear
        bus_op(1'b0, 1'b0, 2'b10, 8'hC3, 2);
        check("R2 B low", code_b, 12'h0C3);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule